// File: doc/BRIEF.md
# Register-Controlled General-Purpose Pin Port

This block is a general-purpose digital pin port that software controls through a small word-addressed register bus. Each pin has three parts: an output latch, an output-enable bit, and an input path that passes through two synchronising flops. The pin count always equals the register width, which is 8, 16, 32 or 64.

Build-time parameters choose how the block behaves:

- The output latch is written either as a whole through a data register, or bit by bit through a set register and a clear register.
- A 1 in the direction register marks either an output or an input.
- The register word can be bit-reversed relative to the pin numbering.
- For 16-bit and 32-bit ports, the byte lanes can be swapped to give big-endian byte order. At 64 bits this option has no effect.

Offsets are fixed:

| Offset | Register | Behaviour |
|---|---|---|
| 0x0 | data | Read: synchronised pin levels. Write: loads the output latch, in single-register mode only. |
| 0x4 | set | Write only; can be made readable by a parameter. |
| 0x8 | clear | Write only. |
| 0xC | direction | Read and write. |

Every other offset reads as zero and ignores writes. In single-register mode, offsets 0x4 and 0x8 are also unimplemented. Read data is registered and appears one clock after the address is presented.

Top module: `gpio_regport`

## Requirements
- R1: After reset the output latch is all zeros and every pin is an input (`pin_oe` all 0). The direction register reads 0 when a 1 marks an output, and reads all ones when a 1 marks an input.
- R2: In single-register mode, a write to offset 0x0 loads the whole output latch. A read of offset 0x0 returns the synchronised pin levels.
- R3: In set/clear mode, a 1 written to offset 0x4 drives that pin to 1, and a 1 written to offset 0x8 drives that pin to 0. Bits written as 0 leave their pins unchanged.
- R4: When the same bit is set and then cleared (or cleared and then set) in successive writes, the pin takes the value of the later write.
- R5: In output-polarity mode a direction bit of 1 enables the pin driver. In input-polarity mode a direction bit of 1 disables it. Offset 0xC reads back the value written.
- R6: With bit reversal enabled, pin n corresponds to register bit WIDTH-1-n on both reads and writes.
- R7: With byte swap enabled at 16 or 32 bits, register byte lane k maps to pin byte lane (WIDTH/8-1-k) on both reads and writes.
- R8: In set/clear mode with the set register readable, a read of offset 0x4 returns the output latch in register bit order. If the set register is not readable, or the block is in single-register mode, that read returns 0.
- R9: A read of offset 0x8 or of any offset other than 0x0, 0x4, 0x8 and 0xC returns 0. Writes to unimplemented offsets change neither the latch nor the direction.
- R10: A change on `pin_in` first appears in a data read issued two clocks after the change; the two reads before it still return the old level.
- R11: For a pin configured as output and looped back externally, a data read returns the driven level.
- R12: In set/clear mode a write to offset 0x0 does not change the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Read data, valid one clock after the address |
| pin_in | input | WIDTH | Pad input levels, asynchronous |
| pin_out | output | WIDTH | Output latch, in pin order |
| pin_oe | output | WIDTH | Output enable, in pin order |

## Verification
The assertions assume that the bus presents one access per cycle. They also assume that address and write enable are stable at the clock edge and that `bus_addr` never carries unknown values outside reset. The bench drives every bus signal on the falling edge, so no transfer overlaps the sampling edge.

Pad inputs may change at any time. The bench changes them only on falling edges, so the two-flop latency it checks (R10) is exact. Three instances with different parameters share one bus. Each write is therefore legal for all of them, and each instance is scored against its own expected pin and register views.

// File: rtl/gpio_regport.sv
module gpio_regport #(
  parameter int WIDTH      = 32,
  parameter int ADDR_W     = 4,
  parameter bit SETCLR     = 1'b0,
  parameter bit DIR_IS_IN  = 1'b0,
  parameter bit BIT_REV    = 1'b0,
  parameter bit BYTE_SWAP  = 1'b0,
  parameter bit SET_RDABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam int  NBYTES   = WIDTH / 8;
  localparam bit  SWAP_EN  = BYTE_SWAP && (WIDTH == 16 || WIDTH == 32);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(4'hC);
  localparam logic [WIDTH-1:0]  DIR_RST  = DIR_IS_IN ? '1 : '0;

  function automatic logic [WIDTH-1:0] lane_swap(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (SWAP_EN)
      for (int b = 0; b < NBYTES; b++)
        r[8*b +: 8] = v[8*(NBYTES-1-b) +: 8];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] reverse(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (BIT_REV)
      for (int i = 0; i < WIDTH; i++)
        r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] out_q, dir_q, sync1, sync2, wr_pins, rd_next;
  logic hit_data, hit_set, hit_clr, hit_dir;

  assign hit_data = bus_addr == OFF_DATA;
  assign hit_set  = bus_addr == OFF_SET;
  assign hit_clr  = bus_addr == OFF_CLR;
  assign hit_dir  = bus_addr == OFF_DIR;
  assign wr_pins  = reverse(lane_swap(bus_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= DIR_RST;
    end else if (bus_we) begin
      if (!SETCLR && hit_data) out_q <= wr_pins;
      if (SETCLR && hit_set)   out_q <= out_q | wr_pins;
      if (SETCLR && hit_clr)   out_q <= out_q & ~wr_pins;
      if (hit_dir)             dir_q <= wr_pins;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_data) rd_next = lane_swap(reverse(sync2));
    if (hit_set && SETCLR && SET_RDABLE) rd_next = lane_swap(reverse(out_q));
    if (hit_dir) rd_next = lane_swap(reverse(dir_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  assign pin_out = out_q;
  assign pin_oe  = DIR_IS_IN ? ~dir_q : dir_q;

  a_r3_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (SETCLR && bus_we && hit_set) |=> ((out_q & $past(out_q)) == $past(out_q)));

  a_r3_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (SETCLR && bus_we && hit_clr) |=> ((out_q & ~$past(out_q)) == '0));

  a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit_data && !hit_set && !hit_clr && !hit_dir) |=> ($stable(out_q) && $stable(dir_q)));

  a_r12_data_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (SETCLR && bus_we && hit_data) |=> $stable(out_q));

  a_r8_set_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!(SETCLR && SET_RDABLE) && hit_set) |=> (bus_rdata == '0));

  a_r1_idle_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: tb/gpio_regport_tb.sv
module gpio_regport_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [3:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [15:0] rd0, po0, oe0, pi0, ext0;
  logic [31:0] rd1, po1, oe1, pi1, ext1;
  logic [7:0]  rd2, po2, oe2, pi2, ext2;

  assign pi0 = (oe0 & po0) | (~oe0 & ext0);
  assign pi1 = (oe1 & po1) | (~oe1 & ext1);
  assign pi2 = (oe2 & po2) | (~oe2 & ext2);

  gpio_regport #(.WIDTH(16), .SETCLR(1'b0), .DIR_IS_IN(1'b0), .BIT_REV(1'b0), .BYTE_SWAP(1'b1))
  u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata[15:0]),
         .bus_rdata(rd0), .pin_in(pi0), .pin_out(po0), .pin_oe(oe0));

  gpio_regport #(.WIDTH(32), .SETCLR(1'b1), .DIR_IS_IN(1'b1), .BIT_REV(1'b1), .BYTE_SWAP(1'b0))
  u_dut1 (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
          .bus_rdata(rd1), .pin_in(pi1), .pin_out(po1), .pin_oe(oe1));

  gpio_regport #(.WIDTH(8), .SETCLR(1'b1), .DIR_IS_IN(1'b0), .SET_RDABLE(1'b0))
  u_dut2 (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata[7:0]),
          .bus_rdata(rd2), .pin_in(pi2), .pin_out(po2), .pin_oe(oe2));

  typedef struct { int unit; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;
  int n_chk = 0, n_err = 0;
  logic rd_req = 1'b0, rd_pend = 1'b0;
  logic [31:0] act;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev32[i] = v[31-i];
  endfunction

  function automatic logic [15:0] sw16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d; rd_req = 1'b0;
  endtask

  task automatic rd(input int u, input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t x;
    @(negedge clk); addr = a; we = 1'b0; rd_req = 1'b1;
    x.unit = u; x.exp = e; x.tag = tag; q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); we = 1'b0; rd_req = 1'b0;
    end
  endtask

  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend) begin
      it = q.pop_front();
      act = (it.unit == 0) ? {16'h0, rd0} : (it.unit == 1) ? rd1 : {24'h0, rd2};
      chk(it.tag, act, it.exp);
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0;
    ext0 = '0; ext1 = '0; ext2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    chk("R1 oe0 reset", {16'h0, oe0}, 32'h0);
    chk("R1 oe1 reset", oe1, 32'h0);
    chk("R1 po1 reset", po1, 32'h0);
    chk("R1 oe2 reset", {24'h0, oe2}, 32'h0);
    rd(0, 4'hC, 32'h0, "R1 dir0 reset");
    rd(1, 4'hC, 32'hFFFF_FFFF, "R1 dir1 reset input polarity");
    rd(2, 4'hC, 32'h0, "R1 dir2 reset");
    rd(1, 4'h4, 32'h0, "R1 latch1 reset");

    wr(4'h0, 32'h0000_1234);
    idle(1);
    chk("R2 R7 po0 data write swapped", {16'h0, po0}, {16'h0, sw16(16'h1234)});
    chk("R12 po1 data write ignored", po1, 32'h0);
    chk("R12 po2 data write ignored", {24'h0, po2}, 32'h0);

    ext0 = 16'hA5C3;
    idle(4);
    rd(0, 4'h0, {16'h0, sw16(16'hA5C3)}, "R2 R7 input read");

    wr(4'hC, 32'h0000_00FF);
    idle(1);
    chk("R5 R7 oe0", {16'h0, oe0}, 32'h0000_FF00);
    chk("R5 R6 oe1 inverted", oe1, ~rev32(32'h0000_00FF));
    chk("R5 oe2", {24'h0, oe2}, 32'h0000_00FF);
    rd(0, 4'hC, 32'h0000_00FF, "R5 dir0 readback");
    rd(1, 4'hC, 32'h0000_00FF, "R5 R6 dir1 readback");
    rd(2, 4'hC, 32'h0000_00FF, "R5 dir2 readback");

    idle(4);
    rd(0, 4'h0, {16'h0, sw16(16'h34C3)}, "R11 loopback read");

    wr(4'h4, 32'h0000_00F0);
    idle(1);
    chk("R9 po0 set offset ignored", {16'h0, po0}, 32'h0000_3412);
    chk("R3 R6 po1 set", po1, rev32(32'h0000_00F0));
    chk("R3 po2 set", {24'h0, po2}, 32'h0000_00F0);
    wr(4'h4, 32'h0000_0003);
    idle(1);
    chk("R3 R6 po1 set keeps others", po1, rev32(32'h0000_00F3));
    chk("R3 po2 set keeps others", {24'h0, po2}, 32'h0000_00F3);
    wr(4'h8, 32'h0000_0030);
    idle(1);
    chk("R3 po1 clear", po1, rev32(32'h0000_00C3));
    chk("R3 po2 clear", {24'h0, po2}, 32'h0000_00C3);
    rd(1, 4'h4, 32'h0000_00C3, "R8 readable set");
    rd(2, 4'h4, 32'h0, "R8 unreadable set");
    rd(1, 4'h8, 32'h0, "R9 clear reads zero");

    wr(4'h4, 32'h0000_0100);
    wr(4'h8, 32'h0000_0100);
    idle(1);
    chk("R4 set then clear", po1, rev32(32'h0000_00C3));
    wr(4'h8, 32'h0000_0100);
    wr(4'h4, 32'h0000_0100);
    idle(1);
    chk("R4 clear then set", po1, rev32(32'h0000_01C3));

    wr(4'h2, 32'hFFFF_FFFF);
    idle(1);
    chk("R9 po0 unchanged", {16'h0, po0}, 32'h0000_3412);
    chk("R9 oe0 unchanged", {16'h0, oe0}, 32'h0000_FF00);
    chk("R9 po1 unchanged", po1, rev32(32'h0000_01C3));
    chk("R9 oe1 unchanged", oe1, ~rev32(32'h0000_00FF));
    chk("R9 po2 unchanged", {24'h0, po2}, 32'h0000_00C3);
    rd(0, 4'h2, 32'h0, "R9 odd offset reads zero");
    rd(0, 4'h4, 32'h0, "R8 set read zero in single mode");

    idle(4);
    @(negedge clk);
    ext0 = 16'hA55A; addr = 4'h0; we = 1'b0; rd_req = 1'b1;
    it.unit = 0; it.exp = {16'h0, sw16(16'h34C3)}; it.tag = "R10 first read old";
    q.push_back(it);
    rd(0, 4'h0, {16'h0, sw16(16'h34C3)}, "R10 second read old");
    rd(0, 4'h0, {16'h0, sw16(16'h345A)}, "R10 third read new");
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule